// File: doc/BRIEF.md
# Check-Bit Protected Word Memory Front End

This block sits between a simple word-addressed request port and a single-port SRAM whose words hold 32 data bits next to 7 check bits. Every stored word is coded for single-error correction and double-error detection. Full-word writes go straight through with freshly computed check bits. Reads are checked and corrected before the data is returned. Writes that cover only some byte lanes are turned into an internal read, merge and write-back sequence.

A two-bit test-access input lets software update only the data part or only the check part of a word, so that errors can be planted and the checking path exercised. Every error found is reported as a one-cycle pulse on a diagnostic port. The pulse carries the error class, the word address, the raw stored data and the stored check code.

The control is a four-state machine. `ST_IDLE` accepts requests. It moves to `ST_RD_CHK` on a read, to `ST_PW_MERGE` on a partial write, or stays in `ST_IDLE` on a full-word write. `ST_RD_CHK` returns the response and goes back to `ST_IDLE`. `ST_PW_MERGE` checks the old word, merges the new lanes into a buffer and moves to `ST_PW_WRITE`. `ST_PW_WRITE` writes the buffer back and returns to `ST_IDLE`.

Top module: `ecc_ram_guard`

## Requirements
- R1: A write with all four lane enables set is taken in the cycle `req_ready` is high. It drives one SRAM write of the data and its check bits in that same cycle, and `req_ready` stays high. A later read returns the data with no event.
- R2: A read drives an SRAM read in its accept cycle. `rsp_valid` and the returned data appear in the next cycle, and `req_ready` is low for exactly that one cycle.
- R3: When a stored word differs from its valid coding in one bit, in either the data part or the check part, a read returns the corrected data. It also raises `evt_valid` for one cycle with `evt_class` = 1, the word address, the raw stored data and the stored check code.
- R4: When a stored word has two bits in error, a read returns the raw stored data and reports `evt_class` = 2 with the same context fields.
- R5: A write with some but not all lane enables set (`req_be[i]` covers bits 8i+7:8i) holds `req_ready` low for two cycles after acceptance. The word that is written back keeps the old lanes and takes the new ones.
- R6: A double error found while reading the old word of a partial write is reported with `evt_class` = 3. The merged word, built from the raw old lanes, is still written back with fresh check bits, so a later read of it is clean.
- R7: A single error found while reading the old word of a partial write is corrected before the merge and reported with `evt_class` = 1.
- R8: With `test_mode` = 2'b10, a write updates only the data part. With 2'b01 it updates only the check part. Codes 2'b00 and 2'b11 update both.
- R9: The following sequence flags a single error at the modified bit and returns the originally written value: write a word in normal mode, rewrite it with one bit flipped under 2'b10, return to normal mode, then read.
- R10: `evt_valid` never rises when the word read is correctly coded. It is never high for two cycles in a row, and it always carries a non-zero class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables for writes |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Corrected read data |
| test_mode | input | 2 | Test-access code: 00/11 normal, 01 check part only, 10 data part only |
| mem_en | output | 1 | SRAM access strobe |
| mem_we_data | output | 1 | SRAM write enable for the data part |
| mem_we_chk | output | 1 | SRAM write enable for the check part |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | 32 | SRAM data part write value |
| mem_wcode | output | 7 | SRAM check part write value |
| mem_rdata | input | 32 | SRAM data part, one cycle after a read |
| mem_rcode | input | 7 | SRAM check part, one cycle after a read |
| evt_valid | output | 1 | Error event pulse |
| evt_class | output | 2 | 1 single, 2 double, 3 double during partial write |
| evt_addr | output | AW | Address of the failing word |
| evt_data | output | 32 | Raw stored data of the failing word |
| evt_code | output | 7 | Stored check code of the failing word |

## Verification
The properties assume that `test_mode` changes only while the block is idle in `ST_IDLE`. They also assume that the SRAM returns the addressed word exactly one cycle after a read strobe and that every input is known once reset is released. The stimulus sets `test_mode` only between requests and waits for `req_ready` before it raises `req_valid`. The SRAM model answers only the reads the block strobes, one cycle later. Errors are planted either through the test-access codes or by flipping bits in the model between requests, never while a request is in flight.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

    localparam int DW     = 32;
    localparam int HB     = 6;
    localparam int CW     = HB + 1;
    localparam int NLANE  = DW / 8;
    localparam int MAXPOS = DW + HB;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_CHK   = 2'd1,
        ST_PW_MERGE = 2'd2,
        ST_PW_WRITE = 2'd3
    } eg_state_e;

    typedef enum logic [1:0] {
        EV_NONE      = 2'd0,
        EV_SINGLE    = 2'd1,
        EV_DOUBLE    = 2'd2,
        EV_DOUBLE_BW = 2'd3
    } eg_evt_e;

    typedef enum logic [1:0] {
        TM_NORMAL    = 2'd0,
        TM_CHK_ONLY  = 2'd1,
        TM_DATA_ONLY = 2'd2,
        TM_NORMAL_B  = 2'd3
    } eg_tmode_e;

    // Code position of data bit i: positions count from 1, powers of two are check slots.
    function automatic logic [HB-1:0] eg_dpos(input int i);
        logic [HB-1:0] r;
        int n;
        r = '0;
        n = 0;
        for (int q = 3; q <= MAXPOS; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == i) r = HB'(q);
                n++;
            end
        end
        return r;
    endfunction

    // Position-sum check bits: xor of the positions of all set data bits.
    function automatic logic [HB-1:0] eg_hamming(input logic [DW-1:0] d);
        logic [HB-1:0] h;
        h = '0;
        for (int i = 0; i < DW; i++) begin
            if (d[i]) h = h ^ eg_dpos(i);
        end
        return h;
    endfunction

endpackage

// File: rtl/eg_secded_enc.sv
module eg_secded_enc
    import ecc_guard_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] code
);
    logic [HB-1:0] pos_sum;

    always_comb begin
        pos_sum = eg_hamming(data);
        // Overall parity covers data and position bits.
        code    = {(^data) ^ (^pos_sum), pos_sum};
    end
endmodule

// File: rtl/eg_secded_dec.sv
module eg_secded_dec
    import ecc_guard_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] code,
    output logic [DW-1:0] corr,
    output logic          err_single,
    output logic          err_double
);
    localparam logic [HB-1:0] LAST_POS = HB'(MAXPOS);

    logic [HB-1:0] syn;
    logic          par;
    logic          fix_data;

    always_comb begin
        syn        = eg_hamming(data) ^ code[HB-1:0];
        par        = (^data) ^ (^code);
        err_single = par && (syn <= LAST_POS);
        err_double = (!par && (syn != '0)) || (par && (syn > LAST_POS));
        // A power-of-two or zero syndrome points at a check slot: data untouched.
        fix_data   = err_single && ((syn & (syn - 1'b1)) != '0);
    end

    for (genvar i = 0; i < DW; i++) begin : g_fix
        localparam logic [HB-1:0] POS = eg_dpos(i);
        assign corr[i] = data[i] ^ (fix_data && (syn == POS));
    end
endmodule

// File: rtl/eg_ctrl.sv
module eg_ctrl
    import ecc_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_write,
    input  logic      req_full,
    output eg_state_e state,
    output logic      req_ready,
    output logic      issue_rd,
    output logic      issue_wr,
    output logic      rsp_valid,
    output logic      chk_cycle,
    output logic      chk_bw,
    output logic      merge_en
);
    eg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)     state_d = ST_RD_CHK;
                    else if (!req_full) state_d = ST_PW_MERGE;
                end
            end
            ST_RD_CHK:   state_d = ST_IDLE;
            ST_PW_MERGE: state_d = ST_PW_WRITE;
            ST_PW_WRITE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        issue_rd  = 1'b0;
        issue_wr  = 1'b0;
        rsp_valid = 1'b0;
        chk_cycle = 1'b0;
        chk_bw    = 1'b0;
        merge_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    issue_wr = req_write && req_full;
                    issue_rd = !(req_write && req_full);
                end
            end
            ST_RD_CHK: begin
                rsp_valid = 1'b1;
                chk_cycle = 1'b1;
            end
            ST_PW_MERGE: begin
                chk_cycle = 1'b1;
                chk_bw    = 1'b1;
                merge_en  = 1'b1;
            end
            ST_PW_WRITE: begin
                issue_wr = 1'b1;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/ecc_ram_guard.sv
module ecc_ram_guard
    import ecc_guard_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [NLANE-1:0]  req_be,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    input  logic [1:0]        test_mode,
    output logic              mem_en,
    output logic              mem_we_data,
    output logic              mem_we_chk,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [CW-1:0]     mem_wcode,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [CW-1:0]     mem_rcode,
    output logic              evt_valid,
    output logic [1:0]        evt_class,
    output logic [AW-1:0]     evt_addr,
    output logic [DW-1:0]     evt_data,
    output logic [CW-1:0]     evt_code
);
    eg_state_e         state;
    logic              issue_rd, issue_wr, chk_cycle, chk_bw, merge_en;
    logic              accept, req_full;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q, merged, merged_q, enc_in, corr;
    logic [NLANE-1:0]  be_q;
    logic [CW-1:0]     enc_code;
    logic              err_single, err_double;

    assign req_full = &req_be;
    assign accept   = req_valid && req_ready;

    eg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_full  (req_full),
        .state     (state),
        .req_ready (req_ready),
        .issue_rd  (issue_rd),
        .issue_wr  (issue_wr),
        .rsp_valid (rsp_valid),
        .chk_cycle (chk_cycle),
        .chk_bw    (chk_bw),
        .merge_en  (merge_en)
    );

    // Request context held for the later phases.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    eg_secded_dec u_dec (
        .data       (mem_rdata),
        .code       (mem_rcode),
        .corr       (corr),
        .err_single (err_single),
        .err_double (err_double)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign merged[8*l +: 8] = be_q[l] ? wdata_q[8*l +: 8] : corr[8*l +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        merged_q <= '0;
        else if (merge_en) merged_q <= merged;
    end

    assign enc_in = (state == ST_PW_WRITE) ? merged_q : req_wdata;

    eg_secded_enc u_enc (
        .data (enc_in),
        .code (enc_code)
    );

    // SRAM side: test-access codes gate the two write enables separately.
    assign mem_en      = issue_rd || issue_wr;
    assign mem_we_data = issue_wr && (test_mode != TM_CHK_ONLY);
    assign mem_we_chk  = issue_wr && (test_mode != TM_DATA_ONLY);
    assign mem_addr    = (state == ST_IDLE) ? req_addr : addr_q;
    assign mem_wdata   = enc_in;
    assign mem_wcode   = enc_code;

    assign rsp_rdata   = corr;

    assign evt_valid   = chk_cycle && (err_single || err_double);
    assign evt_class   = !evt_valid ? EV_NONE :
                         err_single ? EV_SINGLE :
                         chk_bw     ? EV_DOUBLE_BW : EV_DOUBLE;
    assign evt_addr    = addr_q;
    assign evt_data    = mem_rdata;
    assign evt_code    = mem_rcode;
endmodule

// File: rtl/eg_guard_chk.sv
module eg_guard_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [3:0]    req_be,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [1:0]    test_mode,
    input logic          mem_en,
    input logic          mem_we_data,
    input logic          mem_we_chk,
    input logic          evt_valid,
    input logic [1:0]    evt_class,
    input logic [AW-1:0] evt_addr
);
    logic acc_rd, acc_full, acc_part;
    assign acc_rd   = req_valid && req_ready && !req_write;
    assign acc_full = req_valid && req_ready && req_write && (&req_be);
    assign acc_part = req_valid && req_ready && req_write && !(&req_be);

    // R1: full write goes out in the accept cycle, bus stays ready
    assert_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_full && test_mode == 2'b00) |-> (mem_en && mem_we_data && mem_we_chk) ##1 req_ready);

    // R2: read answered in the next cycle with one stall cycle
    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> (rsp_valid && !req_ready) ##1 req_ready);

    assert_resp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_rd));

    // R5: partial write stalls for two cycles
    assert_rmw_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> !req_ready ##1 !req_ready ##1 req_ready);

    // R6: write-back always issued in the second stall cycle
    assert_rmw_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> ##1 (mem_en && (mem_we_data || mem_we_chk)));

    assert_bw_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_class == 2'd3) |-> $past(acc_part));

    // R8: test-access codes block one part of the word
    assert_data_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 2'b10) |-> !mem_we_chk);

    assert_chk_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 2'b01) |-> !mem_we_data);

    // R10: event is a single-cycle pulse with a real class, after a checked access
    assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    assert_evt_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_class != 2'd0));

    assert_evt_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ($past(acc_rd || acc_part) && $stable(evt_addr) == $stable(evt_addr)) );
endmodule

bind ecc_ram_guard eg_guard_chk #(.AW(AW)) u_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_be      (req_be),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .test_mode   (test_mode),
    .mem_en      (mem_en),
    .mem_we_data (mem_we_data),
    .mem_we_chk  (mem_we_chk),
    .evt_valid   (evt_valid),
    .evt_class   (evt_class),
    .evt_addr    (evt_addr)
);

// File: tb/ecc_ram_guard_tb.sv
module ecc_ram_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int EVW   = 2 + AW + 32 + 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic [1:0]    test_mode = 2'b00;
    logic          req_ready, rsp_valid, mem_en, mem_we_data, mem_we_chk, evt_valid;
    logic [31:0]   rsp_rdata, mem_wdata, evt_data;
    logic [31:0]   mem_rdata = '0;
    logic [6:0]    mem_wcode, evt_code;
    logic [6:0]    mem_rcode = '0;
    logic [AW-1:0] mem_addr, evt_addr;
    logic [1:0]    evt_class;

    ecc_ram_guard #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .test_mode(test_mode),
        .mem_en(mem_en), .mem_we_data(mem_we_data), .mem_we_chk(mem_we_chk),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wcode(mem_wcode),
        .mem_rdata(mem_rdata), .mem_rcode(mem_rcode),
        .evt_valid(evt_valid), .evt_class(evt_class), .evt_addr(evt_addr),
        .evt_data(evt_data), .evt_code(evt_code)
    );

    // SRAM model with one-cycle read latency and split write enables.
    logic [31:0] mdata [DEPTH];
    logic [6:0]  mcode [DEPTH];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we_data) mdata[mem_addr] <= mem_wdata;
            if (mem_we_chk)  mcode[mem_addr] <= mem_wcode;
            if (!mem_we_data && !mem_we_chk) begin
                mem_rdata <= mdata[mem_addr];
                mem_rcode <= mcode[mem_addr];
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0]    exp_rsp[$];
    string          exp_rsp_tag[$];
    logic [EVW-1:0] exp_evt[$];
    string          exp_evt_tag[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_rsp(input logic [31:0] d, input string tag);
        exp_rsp.push_back(d);
        exp_rsp_tag.push_back(tag);
    endtask

    task automatic push_evt(input logic [1:0] c, input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [6:0] k, input string tag);
        exp_evt.push_back({c, a, d, k});
        exp_evt_tag.push_back(tag);
    endtask

    // Monitor: pops and compares whenever the design produces a result.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) chk(1'b0, "R2 unexpected response", 64'(rsp_rdata), 64'h0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_rsp.pop_front();
                    t = exp_rsp_tag.pop_front();
                    chk(rsp_rdata === e, t, 64'(rsp_rdata), 64'(e));
                end
            end
            if (evt_valid) begin
                if (exp_evt.size() == 0)
                    chk(1'b0, "R10 unexpected event", 64'({evt_class, evt_addr, evt_data, evt_code}), 64'h0);
                else begin
                    logic [EVW-1:0] e;
                    string t;
                    e = exp_evt.pop_front();
                    t = exp_evt_tag.pop_front();
                    chk({evt_class, evt_addr, evt_data, evt_code} === e, t,
                        64'({evt_class, evt_addr, evt_data, evt_code}), 64'(e));
                end
            end
        end
    end

    // Driver: one request, then count stall cycles.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                         input logic [3:0] be, input int exp_stall, input string tag);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        n = 0;
        while (!req_ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_stall, tag, 64'(n), 64'(exp_stall));
    endtask

    task automatic bwr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
        do_op(1'b1, a, d, be, (be == 4'hF) ? 0 : 2, tag);
    endtask

    task automatic bread(input logic [AW-1:0] a);
        do_op(1'b0, a, 32'h0, 4'h0, 1, "R2 read stall");
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] base, raw, w;
        logic [6:0]  k;
        for (int i = 0; i < DEPTH; i++) begin
            mdata[i] = '0;
            mcode[i] = '0;
        end
        repeat (3) @(negedge clk);
        // Reset state
        chk(req_ready === 1'b1, "R2 ready after reset", 64'(req_ready), 64'h1);
        chk(rsp_valid === 1'b0, "R2 no response in reset", 64'(rsp_valid), 64'h0);
        chk(evt_valid === 1'b0, "R10 no event in reset", 64'(evt_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_en === 1'b0, "R1 idle memory quiet", 64'(mem_en), 64'h0);

        // R1: full-word writes and clean readback over several patterns
        for (int a = 0; a < 8; a++) begin
            w = (a == 0) ? 32'h0 : (a == 1) ? 32'hFFFF_FFFF : (32'hA5C3_0F96 ^ (32'(a) * 32'h0101_0101));
            bwr(AW'(a), w, 4'hF, "R1 full write stall");
            push_rsp(w, "R1 readback");
            bread(AW'(a));
        end

        // R3: every single-bit error, data and check part
        for (int b = 0; b < 39; b++) begin
            base = 32'h600D_F00D ^ (32'(b) * 32'h0102_0408);
            bwr(AW'(10), base, 4'hF, "R1 write before flip");
            @(negedge clk);
            if (b < 32) mdata[10][b] = ~mdata[10][b];
            else        mcode[10][b-32] = ~mcode[10][b-32];
            push_rsp(base, "R3 corrected data");
            push_evt(2'd1, AW'(10), mdata[10], mcode[10], "R3 single event");
            bread(AW'(10));
        end

        // R4: double errors
        base = 32'h1357_9BDF;
        bwr(AW'(11), base, 4'hF, "R1 write");
        @(negedge clk);
        mdata[11][0] = ~mdata[11][0];
        mdata[11][13] = ~mdata[11][13];
        push_rsp(mdata[11], "R4 raw data returned");
        push_evt(2'd2, AW'(11), mdata[11], mcode[11], "R4 double event");
        bread(AW'(11));
        bwr(AW'(12), base, 4'hF, "R1 write");
        @(negedge clk);
        mdata[12][31] = ~mdata[12][31];
        mcode[12][6] = ~mcode[12][6];
        push_rsp(mdata[12], "R4 raw data returned");
        push_evt(2'd2, AW'(12), mdata[12], mcode[12], "R4 double event mixed");
        bread(AW'(12));

        // R5: partial writes merge lanes
        bwr(AW'(20), 32'h1122_3344, 4'hF, "R1 write");
        bwr(AW'(20), 32'hAAAA_AAAA, 4'b0001, "R5 byte write stall");
        push_rsp(32'h1122_33AA, "R5 low lane merged");
        bread(AW'(20));
        bwr(AW'(20), 32'h5566_7788, 4'b0110, "R5 middle lanes stall");
        push_rsp(32'h1166_77AA, "R5 middle lanes merged");
        bread(AW'(20));
        bwr(AW'(20), 32'hEE00_0000, 4'b1000, "R5 top lane stall");
        bwr(AW'(20), 32'h0000_BEEF, 4'b0011, "R5 half word stall");
        push_rsp(32'hEE66_BEEF, "R5 top lane and half word merged");
        bread(AW'(20));

        // R7: single error corrected before the merge
        bwr(AW'(21), 32'h0F0F_0F0F, 4'hF, "R1 write");
        @(negedge clk);
        mdata[21][31] = ~mdata[21][31];
        push_evt(2'd1, AW'(21), mdata[21], mcode[21], "R7 single during partial write");
        bwr(AW'(21), 32'h0000_0055, 4'b0001, "R7 stall");
        push_rsp(32'h0F0F_0F55, "R7 corrected merge");
        bread(AW'(21));

        // R6: double error during partial write, merged word written back clean
        bwr(AW'(22), 32'h2468_ACE0, 4'hF, "R1 write");
        @(negedge clk);
        mdata[22][4] = ~mdata[22][4];
        mdata[22][20] = ~mdata[22][20];
        raw = mdata[22];
        push_evt(2'd3, AW'(22), raw, mcode[22], "R6 double on partial write");
        bwr(AW'(22), 32'h0000_BEEF, 4'b0011, "R6 stall");
        push_rsp({raw[31:16], 16'hBEEF}, "R6 written back clean");
        bread(AW'(22));

        // R8/R9: test access 10 touches data only, then a read flags one bit
        bwr(AW'(30), 32'hCAFE_DECA, 4'hF, "R1 write");
        k = mcode[30];
        test_mode = 2'b10;
        bwr(AW'(30), 32'hCAFE_DECB, 4'hF, "R8 stall in data-only mode");
        chk(mcode[30] === k, "R8 check part kept under 10", 64'(mcode[30]), 64'(k));
        chk(mdata[30] === 32'hCAFE_DECB, "R8 data part written under 10", 64'(mdata[30]), 64'hCAFEDECB);
        test_mode = 2'b00;
        push_rsp(32'hCAFE_DECA, "R9 original value returned");
        push_evt(2'd1, AW'(30), 32'hCAFE_DECB, k, "R9 single error flagged");
        bread(AW'(30));

        // R8: test access 01 touches check part only
        bwr(AW'(31), 32'h1234_5678, 4'hF, "R1 write");
        test_mode = 2'b01;
        bwr(AW'(31), 32'h1234_5679, 4'hF, "R8 stall in check-only mode");
        chk(mdata[31] === 32'h1234_5678, "R8 data part kept under 01", 64'(mdata[31]), 64'h12345678);
        test_mode = 2'b00;
        k = mcode[31];
        push_rsp(32'h1234_5679, "R8 check-only code decodes to new word");
        push_evt(2'd1, AW'(31), 32'h1234_5678, k, "R8 single error from check-only write");
        bread(AW'(31));

        // R8: code 11 behaves as normal
        test_mode = 2'b11;
        bwr(AW'(32), 32'hDEAD_0001, 4'hF, "R8 stall in mode 11");
        test_mode = 2'b00;
        push_rsp(32'hDEAD_0001, "R8 mode 11 writes both parts");
        bread(AW'(32));

        repeat (4) @(negedge clk);
        chk(exp_rsp.size() == 0, "R2 all responses seen", 64'(exp_rsp.size()), 64'h0);
        chk(exp_evt.size() == 0, "R10 all events seen", 64'(exp_evt.size()), 64'h0);
        finish_run();
    end
endmodule